// File: doc/BRIEF.md
# Non-Surjective Message Framing Unit

This block sits between the variable-node update logic and the check-node message store of a layered min-sum style decoder. On the framing path it takes an unsaturated signed message, clips it to the narrower processing alphabet, passes the magnitude through a programmable odd, non-decreasing map whose image is a strict subset of that alphabet, and stores only the position of the result among the distinct image magnitudes together with a sign bit. The stored code is therefore far narrower than the saturated value.

On the de-framing path a stored code is turned back into the signed value in the image of the map that it stands for. Both paths are registered with one cycle of latency and work independently, so one code can be produced and another restored in the same cycle. The map is held in a small register table, loaded at reset from a parameter and rewritable one entry at a time through a write port.

Top module: `nsf_frame_unit`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `fr_code_valid` and `df_data_valid` are low and `fr_code` and `df_data` are zero; the map table holds the `INIT_MAP` parameter (entry k at bits [k*MAG_W +: MAG_W], MAG_W = SAT_W-1).
- R2: A framing input greater than +PEAK or less than -PEAK (PEAK = 2^(SAT_W-1)-1, 7 by default) is treated exactly as +PEAK or -PEAK.
- R3: The framed code has the sign in its top bit (1 = negative) and, in the lower CODE_W-1 bits, the rank of F(|s|) among the distinct table magnitudes in ascending order starting at 0, where s is the saturated input and F is the table.
- R4: A code never carries the sign bit when the mapped magnitude is zero, and an input of zero with a non-zero table entry 0 (value λ) is framed as +λ, i.e. the code with sign 0 and rank 0.
- R5: `fr_code_valid` is high in exactly the cycle after a cycle with `fr_valid` high, and `fr_code` then carries the code for the `fr_data` of that cycle.
- R6: `df_data_valid` is high in exactly the cycle after a cycle with `df_valid` high, and `df_data` then carries the table magnitude of the code's rank, negated when the code's top bit is 1; it never takes the value -2^(SAT_W-1).
- R7: A code whose rank field is at or beyond the highest rank present in the table restores to ±F(PEAK), the largest table magnitude.
- R8: A write with `map_we` high replaces table entry `map_idx` by `map_val` at the next clock edge; a framing request in the same cycle as the write still uses the previous table, one in the next cycle uses the new entry.
- R9: For every input x, de-framing the code produced by framing x yields F(|sat(x)|) with the sign of sat(x), and +F(0) for x = 0.
- R10: When a rank exceeds 2^(CODE_W-1)-1 it is coded as 2^(CODE_W-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Table entry write strobe |
| map_idx | input | SAT_W-1 | Table entry index (input magnitude) |
| map_val | input | SAT_W-1 | New mapped magnitude for that entry |
| fr_valid | input | 1 | Framing request |
| fr_data | input | IN_W | Signed unsaturated message to frame |
| fr_code_valid | output | 1 | Framed code valid |
| fr_code | output | CODE_W | Framed code: sign bit over rank field |
| df_valid | input | 1 | De-framing request |
| df_code | input | CODE_W | Stored code to restore |
| df_data_valid | output | 1 | Restored value valid |
| df_data | output | SAT_W | Signed restored value in the map image |

## Verification
The bench builds two copies side by side: one with the default 6-bit input, 4-bit alphabet and 3-bit code and the zero-preserving table, and one with a 2-bit code and a table whose entry 0 is non-zero. The first copy, through table rewrites, reaches the ranks beyond the populated image (R7), the clipping of ranks too large for the code (R10), a negative input mapped to zero, and the write-versus-frame ordering. The second copy brings the +λ treatment of zero and a one-bit rank field within reach, and both copies are swept over every input for the frame-then-restore identity.

// File: rtl/nsf_pkg.sv
package nsf_pkg;

   // Largest magnitude of a symmetric signed alphabet of the given width.
   function automatic int nsf_peak(input int width);
      return (1 << (width - 1)) - 1;
   endfunction

endpackage

// File: rtl/nsf_map_regs.sv
module nsf_map_regs #(
   parameter int MAG_W   = 3,
   parameter int ENTRIES = 8,
   parameter logic [ENTRIES*MAG_W-1:0] INIT_MAP = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [MAG_W-1:0]         idx,
   input  logic [MAG_W-1:0]         val,
   output logic [ENTRIES*MAG_W-1:0] map_flat
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            map_flat[g*MAG_W +: MAG_W] <= INIT_MAP[g*MAG_W +: MAG_W];
         end else if (we && (idx == MAG_W'(g))) begin
            map_flat[g*MAG_W +: MAG_W] <= val;
         end
      end
   end

endmodule

// File: rtl/nsf_rank_table.sv
module nsf_rank_table #(
   parameter int MAG_W   = 3,
   parameter int ENTRIES = 8,
   parameter int RANK_W  = 2
) (
   input  logic [ENTRIES*MAG_W-1:0]  map_flat,
   output logic [ENTRIES*RANK_W-1:0] rank_flat
);

   localparam int CNT_W = MAG_W + 1;
   localparam int RMAX  = (1 << RANK_W) - 1;

   logic [CNT_W-1:0] raw [ENTRIES];

   // Running count of value changes along the non-decreasing table.
   always_comb begin
      raw[0] = '0;
      for (int k = 1; k < ENTRIES; k++) begin
         raw[k] = raw[k-1] +
                  CNT_W'(map_flat[k*MAG_W +: MAG_W] != map_flat[(k-1)*MAG_W +: MAG_W]);
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_out
      if (RANK_W >= CNT_W) begin : g_wide
         assign rank_flat[g*RANK_W +: RANK_W] = RANK_W'(raw[g]);
      end else begin : g_clip
         localparam logic [CNT_W-1:0] RMAX_C = CNT_W'(RMAX);
         assign rank_flat[g*RANK_W +: RANK_W] =
            (raw[g] > RMAX_C) ? RANK_W'(RMAX) : raw[g][RANK_W-1:0];
      end
   end

endmodule

// File: rtl/nsf_framer.sv
module nsf_framer
   import nsf_pkg::*;
#(
   parameter int IN_W    = 6,
   parameter int SAT_W   = 4,
   parameter int CODE_W  = 3,
   parameter int MAG_W   = SAT_W - 1,
   parameter int ENTRIES = 1 << MAG_W,
   parameter int RANK_W  = CODE_W - 1
) (
   input  logic signed [IN_W-1:0]     din,
   input  logic [ENTRIES*MAG_W-1:0]   map_flat,
   input  logic [ENTRIES*RANK_W-1:0]  rank_flat,
   output logic [CODE_W-1:0]          code
);

   localparam int PEAK = nsf_peak(SAT_W);
   localparam logic signed [IN_W-1:0] SAT_HI = IN_W'(PEAK);
   localparam logic signed [IN_W-1:0] SAT_LO = -SAT_HI;

   logic signed [IN_W-1:0] sat;
   logic [IN_W-1:0]        abs_v;
   logic                   neg;
   logic [MAG_W-1:0]       mag;
   logic [MAG_W-1:0]       img;
   logic [RANK_W-1:0]      rnk;

   always_comb begin
      if (din > SAT_HI)      sat = SAT_HI;
      else if (din < SAT_LO) sat = SAT_LO;
      else                   sat = din;
      neg   = sat < 0;
      abs_v = neg ? IN_W'(-sat) : IN_W'(sat);
      mag   = MAG_W'(abs_v);
      img   = map_flat[mag*MAG_W +: MAG_W];
      rnk   = rank_flat[mag*RANK_W +: RANK_W];
      code  = {neg && (img != '0), rnk};
   end

endmodule

// File: rtl/nsf_deframer.sv
module nsf_deframer #(
   parameter int SAT_W   = 4,
   parameter int CODE_W  = 3,
   parameter int MAG_W   = SAT_W - 1,
   parameter int ENTRIES = 1 << MAG_W,
   parameter int RANK_W  = CODE_W - 1
) (
   input  logic [CODE_W-1:0]          code,
   input  logic [ENTRIES*MAG_W-1:0]   map_flat,
   input  logic [ENTRIES*RANK_W-1:0]  rank_flat,
   output logic signed [SAT_W-1:0]    dout
);

   logic [RANK_W-1:0] rsel;
   logic [MAG_W-1:0]  mag;
   logic [SAT_W-1:0]  wide;

   // Largest table entry whose rank does not exceed the requested one.
   always_comb begin
      rsel = code[RANK_W-1:0];
      mag  = map_flat[0 +: MAG_W];
      for (int k = 1; k < ENTRIES; k++) begin
         if (rank_flat[k*RANK_W +: RANK_W] <= rsel) begin
            mag = map_flat[k*MAG_W +: MAG_W];
         end
      end
      wide = {1'b0, mag};
      dout = code[CODE_W-1] ? -$signed(wide) : $signed(wide);
   end

endmodule

// File: rtl/nsf_frame_unit.sv
module nsf_frame_unit #(
   parameter int IN_W   = 6,
   parameter int SAT_W  = 4,
   parameter int CODE_W = 3,
   parameter logic [(1 << (SAT_W-1))*(SAT_W-1)-1:0] INIT_MAP =
      {3'd7, 3'd7, 3'd3, 3'd3, 3'd3, 3'd1, 3'd1, 3'd0}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     map_we,
   input  logic [SAT_W-2:0]         map_idx,
   input  logic [SAT_W-2:0]         map_val,
   input  logic                     fr_valid,
   input  logic signed [IN_W-1:0]   fr_data,
   output logic                     fr_code_valid,
   output logic [CODE_W-1:0]        fr_code,
   input  logic                     df_valid,
   input  logic [CODE_W-1:0]        df_code,
   output logic                     df_data_valid,
   output logic signed [SAT_W-1:0]  df_data
);

   localparam int MAG_W   = SAT_W - 1;
   localparam int ENTRIES = 1 << MAG_W;
   localparam int RANK_W  = CODE_W - 1;

   if (SAT_W < 2) begin : g_bad_sat
      $error("SAT_W must be at least 2");
   end
   if (IN_W <= SAT_W) begin : g_bad_in
      $error("IN_W must exceed SAT_W");
   end
   if ((CODE_W < 2) || (CODE_W > SAT_W)) begin : g_bad_code
      $error("CODE_W must lie in 2..SAT_W");
   end

   logic [ENTRIES*MAG_W-1:0]  map_flat;
   logic [ENTRIES*RANK_W-1:0] rank_flat;
   logic [CODE_W-1:0]         code_next;
   logic signed [SAT_W-1:0]   data_next;

   nsf_map_regs #(
      .MAG_W(MAG_W), .ENTRIES(ENTRIES), .INIT_MAP(INIT_MAP)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .we(map_we), .idx(map_idx), .val(map_val),
      .map_flat(map_flat)
   );

   nsf_rank_table #(
      .MAG_W(MAG_W), .ENTRIES(ENTRIES), .RANK_W(RANK_W)
   ) u_rank (
      .map_flat(map_flat), .rank_flat(rank_flat)
   );

   nsf_framer #(
      .IN_W(IN_W), .SAT_W(SAT_W), .CODE_W(CODE_W),
      .MAG_W(MAG_W), .ENTRIES(ENTRIES), .RANK_W(RANK_W)
   ) u_fra (
      .din(fr_data), .map_flat(map_flat), .rank_flat(rank_flat), .code(code_next)
   );

   nsf_deframer #(
      .SAT_W(SAT_W), .CODE_W(CODE_W),
      .MAG_W(MAG_W), .ENTRIES(ENTRIES), .RANK_W(RANK_W)
   ) u_dfr (
      .code(df_code), .map_flat(map_flat), .rank_flat(rank_flat), .dout(data_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fr_code_valid <= 1'b0;
         fr_code       <= '0;
         df_data_valid <= 1'b0;
         df_data       <= '0;
      end else begin
         fr_code_valid <= fr_valid;
         df_data_valid <= df_valid;
         if (fr_valid) fr_code <= code_next;
         if (df_valid) df_data <= data_next;
      end
   end

endmodule

// File: rtl/nsf_frame_unit_chk.sv
module nsf_frame_unit_chk #(
   parameter int IN_W   = 6,
   parameter int SAT_W  = 4,
   parameter int CODE_W = 3
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic                                    map_we,
   input logic [SAT_W-2:0]                        map_idx,
   input logic [SAT_W-2:0]                        map_val,
   input logic                                    fr_valid,
   input logic signed [IN_W-1:0]                  fr_data,
   input logic                                    fr_code_valid,
   input logic [CODE_W-1:0]                       fr_code,
   input logic                                    df_valid,
   input logic                                    df_data_valid,
   input logic signed [SAT_W-1:0]                 df_data,
   input logic [(1 << (SAT_W-1))*(SAT_W-1)-1:0]   map_flat
);

   localparam int MAG_W = SAT_W - 1;
   localparam logic signed [SAT_W-1:0] MOST_NEG = {1'b1, {(SAT_W-1){1'b0}}};

   logic             wr_seen;
   logic [MAG_W-1:0] wr_idx;
   logic [MAG_W-1:0] wr_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_seen <= 1'b0;
         wr_idx  <= '0;
         wr_val  <= '0;
      end else begin
         wr_seen <= map_we;
         wr_idx  <= map_idx;
         wr_val  <= map_val;
      end
   end

   // R1
   rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!fr_code_valid && !df_data_valid));

   // R5
   fr_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fr_valid |=> fr_code_valid);

   // R5
   fr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fr_valid |=> !fr_code_valid);

   // R6
   df_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      df_valid |=> df_data_valid);

   // R6
   df_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !df_valid |=> !df_data_valid);

   // R6
   df_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      df_data_valid |-> (df_data != MOST_NEG));

   // R4
   fr_pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_valid && (fr_data >= 0)) |=> !fr_code[CODE_W-1]);

   // R8
   map_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_seen |-> (map_flat[wr_idx*MAG_W +: MAG_W] == wr_val));

endmodule

bind nsf_frame_unit nsf_frame_unit_chk #(
   .IN_W(IN_W), .SAT_W(SAT_W), .CODE_W(CODE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_idx(map_idx), .map_val(map_val),
   .fr_valid(fr_valid), .fr_data(fr_data), .fr_code_valid(fr_code_valid),
   .fr_code(fr_code), .df_valid(df_valid), .df_data_valid(df_data_valid),
   .df_data(df_data), .map_flat(map_flat)
);

// File: tb/nsf_frame_unit_test.sv
`timescale 1ns/1ps
module nsf_frame_unit_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              map_we = 1'b0;
   logic [2:0]        map_idx = '0;
   logic [2:0]        map_val = '0;
   logic              fr_valid = 1'b0;
   logic signed [5:0] fr_data = '0;
   logic              df_valid = 1'b0;
   logic [2:0]        df_code3 = '0;
   logic [1:0]        df_code2 = '0;

   logic              fr_cv3, fr_cv2, df_dv3, df_dv2;
   logic [2:0]        fr_code3;
   logic [1:0]        fr_code2;
   logic signed [3:0] df_data3, df_data2;

   nsf_frame_unit uut (
      .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_idx(map_idx), .map_val(map_val),
      .fr_valid(fr_valid), .fr_data(fr_data), .fr_code_valid(fr_cv3), .fr_code(fr_code3),
      .df_valid(df_valid), .df_code(df_code3), .df_data_valid(df_dv3), .df_data(df_data3)
   );

   nsf_frame_unit #(
      .CODE_W(2),
      .INIT_MAP({3'd6, 3'd6, 3'd6, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1})
   ) uut_w2 (
      .clk(clk), .rst_n(rst_n), .map_we(1'b0), .map_idx(3'd0), .map_val(3'd0),
      .fr_valid(fr_valid), .fr_data(fr_data), .fr_code_valid(fr_cv2), .fr_code(fr_code2),
      .df_valid(df_valid), .df_code(df_code2), .df_data_valid(df_dv2), .df_data(df_data2)
   );

   int tbl3 [8] = '{0, 1, 1, 3, 3, 3, 7, 7};
   int tbl2 [8] = '{1, 1, 1, 1, 1, 6, 6, 6};

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   int    q_c3[$], q_c2[$], q_v3[$], q_v2[$];
   string t_c3[$], t_c2[$], t_v3[$], t_v2[$];

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int satv(input int x);
      if (x > 7) return 7;
      if (x < -7) return -7;
      return x;
   endfunction

   // Reference model: sorted list of the distinct table magnitudes.
   function automatic int ecode(input int t[8], input int x, input int w);
      int lst[8];
      int n = 0;
      int s = satv(x);
      int m = (s < 0) ? -s : s;
      int f = t[m];
      int r = 0;
      int rmax = (1 << (w - 1)) - 1;
      for (int i = 0; i < 8; i++)
         if (n == 0 || lst[n-1] != t[i]) begin lst[n] = t[i]; n++; end
      for (int j = 0; j < n; j++) if (lst[j] == f) r = j;
      if (r > rmax) r = rmax;
      return (((s < 0) && (f != 0)) ? (1 << (w - 1)) : 0) | r;
   endfunction

   function automatic int eval(input int t[8], input int code, input int w);
      int lst[8];
      int n = 0;
      int rmax = (1 << (w - 1)) - 1;
      int r = code & rmax;
      int mag;
      for (int i = 0; i < 8; i++)
         if (n == 0 || lst[n-1] != t[i]) begin lst[n] = t[i]; n++; end
      mag = (r >= n - 1 || r >= rmax) ? lst[n-1] : lst[r];
      return ((code >> (w - 1)) & 1) ? -mag : mag;
   endfunction

   function automatic int fsat(input int t[8], input int x);
      int s = satv(x);
      return (s < 0) ? -t[-s] : t[s];
   endfunction

   // Monitor: pops expected items as results appear.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (fr_cv3) begin
            if (q_c3.size() == 0) chk("R5 spurious code w3", 1, 0);
            else chk(t_c3.pop_front(), int'(fr_code3), q_c3.pop_front());
         end
         if (fr_cv2) begin
            if (q_c2.size() == 0) chk("R5 spurious code w2", 1, 0);
            else chk(t_c2.pop_front(), int'(fr_code2), q_c2.pop_front());
         end
         if (df_dv3) begin
            if (q_v3.size() == 0) chk("R6 spurious value w3", 1, 0);
            else chk(t_v3.pop_front(), int'(df_data3), q_v3.pop_front());
         end
         if (df_dv2) begin
            if (q_v2.size() == 0) chk("R6 spurious value w2", 1, 0);
            else chk(t_v2.pop_front(), int'(df_data2), q_v2.pop_front());
         end
      end
   end

   task automatic send(input int x, input string tag);
      fr_valid = 1'b1;
      fr_data  = 6'(x);
      q_c3.push_back(ecode(tbl3, x, 3)); t_c3.push_back({tag, " w3"});
      q_c2.push_back(ecode(tbl2, x, 2)); t_c2.push_back({tag, " w2"});
   endtask

   task automatic frame1(input int x, input string tag);
      @(negedge clk);
      send(x, tag);
      @(negedge clk);
      fr_valid = 1'b0;
   endtask

   task automatic restore(input int c3, input int c2, input int e3, input int e2,
                          input string tag);
      df_valid = 1'b1;
      df_code3 = 3'(c3);
      df_code2 = 2'(c2);
      q_v3.push_back(e3); t_v3.push_back({tag, " w3"});
      q_v2.push_back(e2); t_v2.push_back({tag, " w2"});
   endtask

   task automatic deframe1(input int c3, input int c2, input string tag);
      @(negedge clk);
      restore(c3, c2, eval(tbl3, c3, 3), eval(tbl2, c2, 2), tag);
      @(negedge clk);
      df_valid = 1'b0;
   endtask

   task automatic roundtrip(input int x);
      frame1(x, "R3 frame sweep");
      restore(int'(fr_code3), int'(fr_code2), fsat(tbl3, x), fsat(tbl2, x),
              "R9 round trip");
      @(negedge clk);
      df_valid = 1'b0;
   endtask

   task automatic write3(input int idx, input int val);
      @(negedge clk);
      map_we = 1'b1; map_idx = 3'(idx); map_val = 3'(val);
      @(negedge clk);
      map_we = 1'b0;
      tbl3[idx] = val;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet in reset
      chk("R1 fr_code_valid", int'(fr_cv3), 0);
      chk("R1 df_data_valid", int'(df_dv3), 0);
      chk("R1 fr_code", int'(fr_code3), 0);
      chk("R1 df_data", int'(df_data3), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid low after release", int'(fr_cv3 | df_dv3 | fr_cv2 | df_dv2), 0);

      // R1/R3 default tables; R4 zero (and +lambda on the w2 copy)
      frame1(0, "R4 zero input");
      chk("R4 zero code w2 is +lambda", int'(fr_code2), 0);
      frame1(5, "R3 mid magnitude");
      frame1(-6, "R3 negative");
      frame1(-1, "R3 small negative");
      frame1(20, "R2 saturate high");
      frame1(-32, "R2 saturate low");
      @(negedge clk);
      chk("R5 valid drops when idle", int'(fr_cv3), 0);

      // R5 back-to-back requests
      @(negedge clk);
      send(3, "R5 burst a");
      @(negedge clk);
      send(-7, "R5 burst b");
      @(negedge clk);
      send(1, "R5 burst c");
      @(negedge clk);
      fr_valid = 1'b0;

      // R9 exhaustive round trip over every input
      for (int x = -32; x < 32; x++) roundtrip(x);

      // R6 every code
      for (int c = 0; c < 8; c++) deframe1(c, c & 3, "R6 restore code");

      // R8 write in same cycle as a frame uses the old entry
      @(negedge clk);
      map_we = 1'b1; map_idx = 3'd5; map_val = 3'd7;
      send(5, "R8 frame during write");
      @(negedge clk);
      map_we = 1'b0; fr_valid = 1'b0;
      tbl3[5] = 7;
      frame1(5, "R8 frame after write");
      frame1(-5, "R8 frame after write neg");

      // R7: table with two distinct magnitudes {0,2}
      write3(1, 0); write3(2, 0); write3(3, 0); write3(5, 2);
      write3(4, 2); write3(6, 2); write3(7, 2);
      deframe1(2, 1, "R7 rank beyond image");
      deframe1(3, 2, "R7 top rank positive");
      deframe1(7, 3, "R7 top rank negative");
      deframe1(5, 0, "R6 rank one negative");
      frame1(-2, "R4 negative to zero");
      chk("R4 no sign on zero image", int'(fr_code3), 0);

      // R10: identity table needs eight ranks, code holds four
      for (int k = 1; k < 8; k++) write3(k, k);
      frame1(6, "R10 rank clipped");
      chk("R10 clipped code", int'(fr_code3), 3);
      frame1(-5, "R10 rank clipped neg");
      frame1(2, "R10 rank fits");
      deframe1(3, 1, "R10 clipped code restores peak");

      repeat (3) @(negedge clk);
      chk("R5 all results seen",
          q_c3.size() + q_c2.size() + q_v3.size() + q_v2.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL R5 watchdog: actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule